// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a clocked host to an external asynchronous static RAM that is one byte wide. The host issues one request at a time. Each request carries a write flag, an address and write data, and is accepted when `req_valid` and `req_ready` are both high in the same cycle. A read returns its byte with a response strobe that lasts exactly one cycle. A write returns no response. The controller is ready again once the memory cycle has finished.

On the memory side the controller drives these signals, all from registers:
- the address,
- a select that is active-low and a second select that is active-high,
- an active-low output enable,
- an active-low write enable,
- the write data, together with its own drive enable.

The read data bus comes back on a separate input. Each timing interval is a count of clock cycles, set by a parameter and rounded up from the memory's nanosecond minimum:
- the wait for the memory to release the bus after write enable falls,
- the data setup before the edge that ends the write,
- the read access wait.

Output enable stays low for the whole of every access, writes included. A write therefore always waits for the bus to turn around before the controller drives data. The write ends when write enable rises. The selects and the address are held for one more cycle after that edge.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, and in idle, both selects are inactive (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. After acceptance `req_ready` is low for TURN_CYC+SETUP_CYC+1 cycles on a write and for RD_CYC cycles on a read. A write never produces `rsp_valid`.
- R3: `mem_we_n` is low only while both selects are active. A write pulse lasts TURN_CYC+SETUP_CYC cycles, which covers at least the memory's minimum write pulse width.
- R4: `mem_dq_oe` stays low for the first TURN_CYC cycles after `mem_we_n` falls. The controller never drives the data bus while the memory may be driving it.
- R5: `mem_dq_oe` falls no later than `mem_we_n` rises. The write is ended by `mem_we_n` rising while both selects are still active.
- R6: Write data comes from a register and is driven unchanged for SETUP_CYC cycles before write enable rises. This meets the data setup to the terminating edge.
- R7: A read holds `mem_oe_n`=0 and `mem_we_n`=1 with both selects active for RD_CYC cycles. The bus is captured at the end of the last wait cycle and presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R8: `mem_addr` does not change while either select is active. At the end of a write it has been stable for at least the memory's address-to-write-end time.
- R9: A read returns the byte most recently written to that address. This holds at address 0, at the top address 0x1FFFF, for data 0x00 and 0xFF, and after two back-to-back writes to the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_ce | output | 1 | Memory select, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from the memory bus |

## Verification
The memory model drives its outputs during the float window that follows a write-enable fall. A controller that drives data too early, for example one with no turnaround wait, therefore shows up as bus contention. The model returns unknown data until the access time has passed since the address, the select and the output enable settled, so capturing a read one cycle early yields a mismatch in the scoreboard. At each write end the model measures the pulse width, the data setup and the address setup. It also checks that write enable, and not a select, ended the write, which catches designs that drop the selects too soon or shorten the drive phase. Back-to-back writes to one address and reads at both address extremes reveal a lost or misplaced write.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WTURN = 3'd1,
    ST_WDRV  = 3'd2,
    ST_WHOLD = 3'd3,
    ST_RWAIT = 3'd4
  } st_t;
endpackage

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int TURN_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wr,
  output st_t  st_q,
  output st_t  st_nx,
  output logic cap
);
  localparam int MAXC = (TURN_CYC > SETUP_CYC) ?
                        ((TURN_CYC > RD_CYC) ? TURN_CYC : RD_CYC) :
                        ((SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC);
  localparam int CW = $clog2(MAXC + 2);
  localparam logic [CW-1:0] TURN_LD  = (TURN_CYC  > 0) ? CW'(TURN_CYC - 1)  : '0;
  localparam logic [CW-1:0] SETUP_LD = (SETUP_CYC > 0) ? CW'(SETUP_CYC - 1) : '0;
  localparam logic [CW-1:0] RD_LD    = (RD_CYC    > 0) ? CW'(RD_CYC - 1)    : '0;

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    cap    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (wr) begin
            if (TURN_CYC > 0) begin
              st_nx  = ST_WTURN;
              cnt_nx = TURN_LD;
            end else begin
              st_nx  = ST_WDRV;
              cnt_nx = SETUP_LD;
            end
          end else begin
            st_nx  = ST_RWAIT;
            cnt_nx = RD_LD;
          end
        end
      end
      ST_WTURN: begin
        if (cnt_zero) begin
          st_nx  = ST_WDRV;
          cnt_nx = SETUP_LD;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      ST_WDRV: begin
        if (cnt_zero) st_nx = ST_WHOLD;
        else          cnt_nx = cnt_q - 1'b1;
      end
      ST_WHOLD: st_nx = ST_IDLE;
      ST_RWAIT: begin
        if (cnt_zero) begin
          st_nx = ST_IDLE;
          cap   = 1'b1;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
    end
  end
endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_t           st_nx,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe
);
  logic          sel_nx, we_nx, drv_nx;
  logic [AW-1:0] addr_nx;
  logic [DW-1:0] data_nx;

  always_comb begin
    sel_nx  = (st_nx != ST_IDLE);
    we_nx   = (st_nx == ST_WTURN) || (st_nx == ST_WDRV);
    drv_nx  = (st_nx == ST_WDRV);
    addr_nx = load ? addr  : mem_addr;
    data_nx = load ? wdata : mem_dq_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n   <= 1'b1;
      mem_ce     <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      mem_ce_n   <= ~sel_nx;
      mem_ce     <= sel_nx;
      mem_oe_n   <= ~sel_nx;
      mem_we_n   <= ~we_nx;
      mem_dq_oe  <= drv_nx;
      mem_addr   <= addr_nx;
      mem_dq_out <= data_nx;
    end
  end
endmodule

// File: rtl/sram_ctl_rdcap.sv
`timescale 1ns/1ps
module sram_ctl_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] rdata_nx;

  always_comb rdata_nx = cap ? dq_in : rsp_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap;
      rsp_rdata <= rdata_nx;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int TURN_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  if (SETUP_CYC < 1) begin : g_bad_setup
    $error("sram_ctl: SETUP_CYC must be at least 1");
  end
  if (RD_CYC < 1) begin : g_bad_read
    $error("sram_ctl: RD_CYC must be at least 1");
  end

  st_t  st_q, st_nx;
  logic cap, accept;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_ctl_seq #(
    .TURN_CYC (TURN_CYC),
    .SETUP_CYC(SETUP_CYC),
    .RD_CYC   (RD_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .wr   (req_write),
    .st_q (st_q),
    .st_nx(st_nx),
    .cap  (cap)
  );

  sram_ctl_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_nx     (st_nx),
    .load      (accept),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_ctl_rdcap #(.DW(DW)) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .dq_in    (mem_dq_in),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_ce,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce));

  // R4
  no_drive_at_we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  // R5
  drive_inside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_ce));

  // R5
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce && !mem_dq_oe));

  // R6
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  // R7
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n && mem_we_n && !mem_ce_n && mem_ce));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
  localparam int  CLK_NS    = 10;
  localparam int  TURN_CYC  = 1;
  localparam int  SETUP_CYC = 1;
  localparam int  RD_CYC    = 2;
  localparam real T_ACC     = 12.0;
  localparam real T_OE      = 6.0;
  localparam real T_PWE     = 10.0;
  localparam real T_SD      = 7.0;
  localparam real T_AW      = 10.0;
  localparam real T_FLOAT   = 6.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 'x;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctl #(.TURN_CYC(TURN_CYC), .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- timed memory model ----------------
  logic [7:0] mem_arr [logic [16:0]];
  realtime t_addr = -1000.0, t_sel = -1000.0, t_oe = -1000.0;
  realtime t_wef = -1000.0, t_d = -1000.0, t_ws = -1000.0;
  bit      wr_act = 1'b0;
  bit      saw_drv = 1'b0;
  logic [7:0] wdat = '0;

  always @(mem_addr) t_addr = $realtime;
  always @(mem_ce_n or mem_ce) t_sel = $realtime;
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(negedge mem_we_n) t_wef = $realtime;
  always @(mem_dq_oe or mem_dq_out) if (mem_dq_oe === 1'b1) t_d = $realtime;

  always @(mem_we_n or mem_ce_n or mem_ce) begin
    bit wn;
    wn = (mem_we_n === 1'b0) && (mem_ce_n === 1'b0) && (mem_ce === 1'b1);
    if (wn && !wr_act) begin
      t_ws    = $realtime;
      saw_drv = 1'b0;
    end else if (!wn && wr_act) begin
      // R3 pulse width, R5 terminating edge, R6 data setup, R8 address setup
      chk(($realtime - t_ws) >= T_PWE, "R3", "write pulse ns",
          int'($realtime - t_ws), int'(T_PWE));
      chk(mem_we_n === 1'b1 && mem_ce_n === 1'b0 && mem_ce === 1'b1, "R5",
          "write not ended by write enable", int'(mem_we_n), 1);
      chk(saw_drv && ($realtime - t_d) >= T_SD, "R6", "data setup ns",
          int'($realtime - t_d), int'(T_SD));
      chk(($realtime - t_addr) >= T_AW, "R8", "address setup ns",
          int'($realtime - t_addr), int'(T_AW));
      mem_arr[mem_addr] = wdat;
    end
    wr_act = wn;
  end

  always @(negedge clk) begin
    bit rd, sel;
    sel = (mem_ce_n === 1'b0) && (mem_ce === 1'b1);
    rd  = sel && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
    if (rd && ($realtime - t_addr) >= T_ACC && ($realtime - t_sel) >= T_ACC &&
        ($realtime - t_oe) >= T_OE && mem_arr.exists(mem_addr))
      mem_dq_in = mem_arr[mem_addr];
    else
      mem_dq_in = 'x;
    if (wr_act && mem_dq_oe === 1'b1) begin
      wdat    = mem_dq_out;
      saw_drv = 1'b1;
    end
    if (mem_dq_oe === 1'b1)
      // R4 contention with memory output or its float window
      chk(!(rd || (sel && mem_oe_n === 1'b0 && ($realtime - t_wef) < T_FLOAT)),
          "R4", "bus contention", 1, 0);
  end

  // ---------------- scoreboard ----------------
  logic [7:0] shadow [logic [16:0]];
  logic [7:0] exp_q [$];
  int         n_rd = 0;
  int         n_rsp = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid === 1'b1) begin
      n_rsp++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "response without pending read", 1, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        // R7 R9 read data
        chk(rsp_rdata === e, "R9", "read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       output int busy);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    busy = 0;
    while (req_ready !== 1'b1 && busy < 50) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int busy;
    shadow[a] = d;
    issue(1'b1, a, d, busy);
    chk(busy == TURN_CYC + SETUP_CYC + 1, "R2", "write busy cycles",
        busy, TURN_CYC + SETUP_CYC + 1);
  endtask

  task automatic do_read(input logic [16:0] a);
    int busy;
    exp_q.push_back(shadow[a]);
    n_rd++;
    issue(1'b0, a, 8'h00, busy);
    chk(busy == RD_CYC, "R2", "read busy cycles", busy, RD_CYC);
    // R7 response strobe visible in the cycle ready returns
    chk(rsp_valid === 1'b1, "R7", "response strobe timing", int'(rsp_valid), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n === 1'b1 && mem_ce === 1'b0, "R1", "selects in reset",
        int'({mem_ce_n, mem_ce}), 2);
    chk(mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1", "strobes in reset",
        int'({mem_oe_n, mem_we_n}), 3);
    chk(mem_dq_oe === 1'b0 && rsp_valid === 1'b0, "R1", "drive/rsp in reset",
        int'({mem_dq_oe, rsp_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && mem_ce_n === 1'b1, "R1", "idle after reset",
        int'({req_ready, mem_ce_n}), 3);

    // extremes of address and data
    do_write(17'h00000, 8'h00);
    do_write(17'h1FFFF, 8'hFF);
    do_write(17'h00055, 8'hA5);
    do_write(17'h0AAAA, 8'h5A);
    do_read(17'h1FFFF);
    do_read(17'h00000);
    do_read(17'h0AAAA);
    do_read(17'h00055);

    // back-to-back writes to one address
    do_write(17'h00100, 8'h11);
    do_write(17'h00100, 8'h22);
    do_read(17'h00100);

    // interleaved write / read pattern
    for (int i = 0; i < 8; i++) begin
      logic [16:0] a;
      logic [7:0]  d;
      a = 17'((i * 4099 + 7) & 17'h1FFFF);
      d = 8'((i * 37 + 3) & 8'hFF);
      do_write(a, d);
      do_read(a);
    end
    do_read(17'h1FFFF);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "pending reads left", exp_q.size(), 0);
    chk(n_rsp == n_rd, "R2", "response count", n_rsp, n_rd);
    chk(mem_ce_n === 1'b1 && mem_we_n === 1'b1 && mem_dq_oe === 1'b0, "R1",
        "idle at end", int'({mem_ce_n, mem_we_n, mem_dq_oe}), 6);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule